// File: doc/BRIEF.md
# Transmit Collision Retry Policy Controller

This block decides what a half-duplex network transmitter does when one packet keeps colliding. It counts consecutive collisions on the packet in flight. When the count reaches the limit, it does one of two things, depending on a programmed policy. It can stop and wait for software. Or it can act on its own, either by trying the same packet again or by dropping it and moving on to the next queued packet.

Software programs the policy, and answers a halt, by writing one-byte action codes through a single write strobe. The MAC reports each collision, each successful transmission and each packet start as one-cycle pulses. A queue status bit says whether another packet waits behind the current one. The block sends single-cycle retry and skip pulses toward the packet queue. It also drives a halt status, a sticky excessive-collision interrupt and a transmit-done status.

Top module: `tx_coll_policy`

## Requirements
- R1: After reset the counter is zero, the policy is "halt on exhaustion", and `halted`, `irq`, `tx_done`, `retry_pulse` and `skip_pulse` are all 0.
- R2: In halt policy, collisions 1 to LIMIT-1 (LIMIT = 16) produce no output change. Collision number LIMIT sets `halted` and `irq` to 1 on the next cycle, with no retry or skip pulse.
- R3: While `halted` is 1, collision pulses are ignored: no retry or skip pulse is issued and `halted` stays 1.
- R4: While halted, code 0x02 clears `halted` and `irq` and issues one `retry_pulse` on the next cycle. The counter restarts, so a further LIMIT collisions are needed to halt again.
- R5: While halted, code 0x03 clears `halted` and `irq` and issues one `skip_pulse`. If `queue_more` is 0 in that cycle, `tx_done` is set to 1, and it stays 1 until a `pkt_start` pulse.
- R6: Code 0x06 selects automatic repeat. Every LIMIT-th consecutive collision issues one `retry_pulse` and restarts the counter, and the block never halts.
- R7: Code 0x07 selects automatic skip. Every LIMIT-th consecutive collision issues one `skip_pulse`, and `tx_done` is set when `queue_more` is 0 in that cycle.
- R8: A `tx_ok` or `pkt_start` pulse clears the collision counter, so LIMIT fresh collisions are needed before an exhaustion action.
- R9: Code 0x02 or 0x03 written while not halted only selects halt policy, with no pulse. Any code other than 0x02, 0x03, 0x06 or 0x07 leaves the policy unchanged.
- R10: `retry_pulse` and `skip_pulse` last one cycle each, are never high together, and each exhaustion or resume event issues at most one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Action-code write strobe |
| cmd_code | input | CODE_W | Action code |
| coll | input | 1 | One-cycle collision report |
| tx_ok | input | 1 | One-cycle successful-transmission report |
| pkt_start | input | 1 | One-cycle start of a new packet |
| queue_more | input | 1 | Another packet waits behind the current one |
| retry_pulse | output | 1 | Retransmit the current packet |
| skip_pulse | output | 1 | Drop the current packet and take the next |
| halted | output | 1 | Transmitter halted on excessive collisions |
| irq | output | 1 | Sticky excessive-collision interrupt |
| tx_done | output | 1 | Transmitter deactivated after a skip with an empty queue |

## Verification
Every output is registered. A stimulus presented in one cycle therefore appears on the outputs exactly one cycle later: the LIMIT-th collision, a resume command, a policy write, or a counter-clearing pulse. Pulses are back to 0 one cycle after that. The bench drives each input for one clock cycle between falling edges. It samples on the falling edge right after the rising edge that captured the input, which is where the result is due, and again one edge later to confirm that pulses end. In collision runs it checks after every collision that nothing happens before the LIMIT-th one.

// File: rtl/tx_coll_policy.sv
module tx_coll_policy #(
  parameter int LIMIT  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              coll,
  input  logic              tx_ok,
  input  logic              pkt_start,
  input  logic              queue_more,
  output logic              retry_pulse,
  output logic              skip_pulse,
  output logic              halted,
  output logic              irq,
  output logic              tx_done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CODE_W-1:0] OP_HALT_REP  = CODE_W'(2);
  localparam logic [CODE_W-1:0] OP_HALT_SKIP = CODE_W'(3);
  localparam logic [CODE_W-1:0] OP_AUTO_REP  = CODE_W'(6);
  localparam logic [CODE_W-1:0] OP_AUTO_SKIP = CODE_W'(7);
  localparam logic [CW-1:0]     LAST         = CW'(LIMIT - 1);

  typedef enum logic [1:0] {P_HALT, P_AUTO_REP, P_AUTO_SKIP} policy_t;

  policy_t       policy;
  logic [CW-1:0] cnt;
  logic          halt_q, xcoll_q, done_q, retry_q, skip_q;

  wire wr_rep  = cmd_wr && (cmd_code == OP_HALT_REP);
  wire wr_skp  = cmd_wr && (cmd_code == OP_HALT_SKIP);
  wire resume  = halt_q && (wr_rep || wr_skp);
  wire restart = tx_ok || pkt_start;
  wire counted = coll && !halt_q;
  wire exhaust = counted && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      policy  <= P_HALT;
      cnt     <= '0;
      halt_q  <= 1'b0;
      xcoll_q <= 1'b0;
      done_q  <= 1'b0;
      retry_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      skip_q  <= 1'b0;
      if (pkt_start) done_q <= 1'b0;

      if (wr_rep || wr_skp)                              policy <= P_HALT;
      else if (cmd_wr && cmd_code == OP_AUTO_REP)        policy <= P_AUTO_REP;
      else if (cmd_wr && cmd_code == OP_AUTO_SKIP)       policy <= P_AUTO_SKIP;

      if (resume) begin
        halt_q  <= 1'b0;
        xcoll_q <= 1'b0;
        cnt     <= '0;
        if (wr_skp) begin
          skip_q <= 1'b1;
          if (!queue_more) done_q <= 1'b1;
        end else begin
          retry_q <= 1'b1;
        end
      end else if (restart) begin
        cnt <= '0;
      end else if (exhaust) begin
        case (policy)
          P_AUTO_REP: begin
            retry_q <= 1'b1;
            cnt     <= '0;
          end
          P_AUTO_SKIP: begin
            skip_q <= 1'b1;
            cnt    <= '0;
            if (!queue_more) done_q <= 1'b1;
          end
          default: begin
            halt_q  <= 1'b1;
            xcoll_q <= 1'b1;
            cnt     <= CW'(LIMIT);
          end
        endcase
      end else if (counted) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign retry_pulse = retry_q;
  assign skip_pulse  = skip_q;
  assign halted      = halt_q;
  assign irq         = xcoll_q;
  assign tx_done     = done_q;

  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_pulse && skip_pulse));
  assert_retry_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> !retry_pulse);
  assert_skip_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |=> !skip_pulse);
  assert_halt_ignores_coll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && coll && !cmd_wr) |=> (halted && !retry_pulse && !skip_pulse));
  assert_irq_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cmd_wr && (cmd_code == OP_HALT_REP || cmd_code == OP_HALT_SKIP))) |=> irq);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  assert_done_from_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> skip_pulse);
  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (!retry_pulse && !skip_pulse && irq));
endmodule

// File: tb/tx_coll_policy_tb.sv
module tx_coll_policy_tb_top;
  localparam int LIMIT = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, coll = 1'b0, tx_ok = 1'b0, pkt_start = 1'b0, queue_more = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic retry_pulse, skip_pulse, halted, irq, tx_done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tx_coll_policy #(.LIMIT(LIMIT), .CODE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .coll(coll),
    .tx_ok(tx_ok), .pkt_start(pkt_start), .queue_more(queue_more),
    .retry_pulse(retry_pulse), .skip_pulse(skip_pulse), .halted(halted),
    .irq(irq), .tx_done(tx_done));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic r, input logic s, input logic h, input logic d);
    chk(req, "retry_pulse", retry_pulse, r);
    chk(req, "skip_pulse", skip_pulse, s);
    chk(req, "halted", halted, h);
    chk(req, "irq", irq, h);
    chk(req, "tx_done", tx_done, d);
  endtask

  task automatic one_coll();
    @(negedge clk) coll = 1'b1;
    @(negedge clk) coll = 1'b0;
  endtask

  task automatic write_code(input logic [7:0] c);
    @(negedge clk) begin cmd_wr = 1'b1; cmd_code = c; end
    @(negedge clk) begin cmd_wr = 1'b0; cmd_code = 8'h00; end
  endtask

  task automatic pulse_start();
    @(negedge clk) pkt_start = 1'b1;
    @(negedge clk) pkt_start = 1'b0;
  endtask

  // n collisions; nothing may happen before the last; last result is checked
  task automatic coll_run(input string req, input int n, input logic r, input logic s,
                          input logic h, input logic d_before, input logic d_after);
    for (int i = 1; i <= n; i++) begin
      one_coll();
      if (i < n) chk_all(req, 1'b0, 1'b0, 1'b0, d_before);
      else       chk_all(req, r, s, h, d_after);
    end
    @(negedge clk);
    chk(req, "pulse ended", retry_pulse | skip_pulse, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_halt_and_repeat();
    coll_run("R2", LIMIT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      one_coll();
      chk_all("R3", 1'b0, 1'b0, 1'b1, 1'b0);
    end
    write_code(8'h02);
    chk_all("R4", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10", "retry single", retry_pulse, 1'b0);
    coll_run("R4", LIMIT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_halt_skip();
    queue_more = 1'b1;
    write_code(8'h03);
    chk_all("R5", 1'b0, 1'b1, 1'b0, 1'b0);
    coll_run("R5", LIMIT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    queue_more = 1'b0;
    write_code(8'h03);
    chk_all("R5", 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R5", "tx_done held", tx_done, 1'b1);
    pulse_start();
    chk("R5", "tx_done cleared by start", tx_done, 1'b0);
  endtask

  task automatic t_auto_repeat();
    write_code(8'h06);
    chk_all("R6", 1'b0, 1'b0, 1'b0, 1'b0);
    coll_run("R6", LIMIT, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    coll_run("R6", LIMIT, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_auto_skip();
    write_code(8'h07);
    queue_more = 1'b1;
    coll_run("R7", LIMIT, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    queue_more = 1'b0;
    coll_run("R7", LIMIT, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    pulse_start();
    chk("R7", "tx_done cleared by start", tx_done, 1'b0);
  endtask

  task automatic t_clear();
    queue_more = 1'b1;
    coll_run("R8", 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk) tx_ok = 1'b1;
    @(negedge clk) tx_ok = 1'b0;
    coll_run("R8", LIMIT, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    coll_run("R8", 12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_start();
    coll_run("R8", LIMIT, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ignore();
    write_code(8'h05);
    write_code(8'hFF);
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    coll_run("R9", LIMIT, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    write_code(8'h02);
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    coll_run("R9", LIMIT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    write_code(8'h02);
    chk_all("R10", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halt_and_repeat();
    t_halt_skip();
    t_auto_repeat();
    t_auto_skip();
    t_clear();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule